// File: doc/BRIEF.md
# Serial Comma Framer with Low-Latency Realignment

This block sits behind a clock/data recovery stage and turns a stream of recovered serial bits, delivered one per clock with a valid strobe, into 10-bit 8B/10B code groups. A 20-bit history of received bits is kept. After every valid bit the newest 10 bits are compared against the selected framing pattern, so a match is found at whatever bit offset it arrives. The older 10 bits are the character that is presented at the output. Each character therefore appears one character time after its last bit arrives. That delay lets the framer realign without ever cutting a character short.

Two framing choices exist. The comma setting matches an 8-bit comma of either running disparity (`00111110xx` or `11000001xx`); checking the eighth bit makes false framing less likely. The K28.5 setting accepts only the complete characters `0011111010` and `1100000101`. When the framer enable is high, the first match moves the character boundary at once: the pending boundary is skipped and the framing character is issued 10 valid bits after the match, with a flag set. When the enable is low the boundary never moves. Any match realigns the framer, including one that straddles two characters, so the enable must be dropped while such data is being received.

Top module: `comma_framer`

## Requirements
- R1: After reset `char_stb` and `char_frm` are low and `char_out` is zero. The boundary counter starts at offset 0, so the first strobe follows the 10th valid bit.
- R2: Without realignment, `char_stb` pulses for one cycle, one clock after every 10th valid bit. Cycles with `bit_vld` low neither advance the boundary nor produce a strobe.
- R3: At a strobe, `char_out` holds the 10 valid bits that ended 10 valid bits before the strobing bit. The earliest of them is in bit 9. Bits before reset count as 0.
- R4: With `char_sel`=0 a match is any 10-bit window whose first eight bits are `00111110` or `11000001`, at any bit offset.
- R5: With `char_sel`=1 only `0011111010` or `1100000101` match. A comma followed by other two bits causes no realignment.
- R6: While `frm_en` is low no bit pattern changes the boundary, and `char_frm` stays low.
- R7: Suppose a match completes d valid bits after the last boundary, with d from 1 to 9. Then the next strobe comes d+10 valid bits after that boundary, which is a period of 11 to 19 bits, and it carries the framing character. No period is ever shorter than 10 bits.
- R8: `char_frm` is high only together with the strobe of the character that held the matched pattern.
- R9: A match that completes exactly on the current boundary leaves the 10-bit period unchanged. The framing character is flagged at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Recovered serial bit, earliest bit of a character first |
| frm_en | input | 1 | Framer enable; low freezes the boundary |
| char_sel | input | 1 | 0: 8-bit comma, 1: full K28.5 only |
| char_out | output | CHAR_W | Aligned character, earliest bit in the MSB |
| char_stb | output | 1 | One-cycle pulse when `char_out` is new |
| char_frm | output | 1 | The strobed character held the framing pattern |

## Verification
The assertions check several properties on every cycle. A strobe follows only a valid bit, and the flag never appears without a strobe. The boundary counter stays in range and restarts on a match. No character period drops below 10 bits, and the boundary does not move while the enable is low. Only the bench's sweeps can show the rest. Those sweeps cover each framing pattern at every offset over two characters, under both select settings and both enable states, with random idle gaps between bits. They show which patterns actually count as matches, the exact 11-to-19-bit stretch, the bit order of the issued characters, and that the flag lands on the framing character.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned CHAR_W  = 10;
  localparam int unsigned COMMA_W = 8;

  // Full framing characters, written with the earliest received bit on the left.
  localparam logic [CHAR_W-1:0] K285_NEG = 10'b0011111010;
  localparam logic [CHAR_W-1:0] K285_POS = 10'b1100000101;

  typedef enum logic {
    SEL_COMMA = 1'b0,
    SEL_K285  = 1'b1
  } frame_sel_e;
endpackage

// File: rtl/bit_history.sv
module bit_history #(
  parameter int unsigned CHAR_W = framer_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [CHAR_W-1:0] window_nxt,
  output logic [CHAR_W-1:0] lagged_nxt
);
  localparam int unsigned HIST_W = 2 * CHAR_W;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (bit_vld) begin
      hist_d = {hist_q[HIST_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (bit_vld) begin
      hist_q <= hist_d;
    end
  end

  assign window_nxt = hist_d[CHAR_W-1:0];
  assign lagged_nxt = hist_d[HIST_W-1:CHAR_W];
endmodule

// File: rtl/comma_detect.sv
module comma_detect #(
  parameter int unsigned CHAR_W  = framer_pkg::CHAR_W,
  parameter int unsigned COMMA_W = framer_pkg::COMMA_W
) (
  input  logic              [CHAR_W-1:0] window,
  input  framer_pkg::frame_sel_e         sel,
  output logic                           hit
);
  localparam int unsigned N_DISP = 2;

  logic [N_DISP-1:0] full_hit;
  logic [N_DISP-1:0] comma_hit;

  for (genvar d = 0; d < N_DISP; d++) begin : g_disp
    localparam logic [CHAR_W-1:0] REF =
      (d == 0) ? framer_pkg::K285_NEG : framer_pkg::K285_POS;
    assign full_hit[d]  = (window == REF);
    assign comma_hit[d] = (window[CHAR_W-1 -: COMMA_W] == REF[CHAR_W-1 -: COMMA_W]);
  end

  always_comb begin
    if (sel == framer_pkg::SEL_K285) begin
      hit = |full_hit;
    end else begin
      hit = |comma_hit;
    end
  end
endmodule

// File: rtl/boundary_ctrl.sv
module boundary_ctrl #(
  parameter int unsigned CHAR_W = framer_pkg::CHAR_W
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_vld,
  input  logic det,
  output logic boundary,
  output logic frm_pend
);
  localparam int unsigned CW = $clog2(CHAR_W);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  always_comb begin
    boundary = bit_vld && (cnt_q == LAST);
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    if (bit_vld) begin
      if (det || boundary) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      if (det) begin
        pend_d = 1'b1;
      end else if (boundary) begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (bit_vld) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign frm_pend = pend_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_REALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_ni)
    (bit_vld && det) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/comma_framer.sv
module comma_framer #(
  parameter int unsigned CHAR_W = framer_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              frm_en,
  input  logic              char_sel,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_stb,
  output logic              char_frm
);
  localparam int unsigned GW = $clog2(2 * CHAR_W) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  logic [CHAR_W-1:0] window_nxt, lagged_nxt;
  logic              hit, det, boundary, frm_pend;
  framer_pkg::frame_sel_e sel;

  assign sel = framer_pkg::frame_sel_e'(char_sel);

  bit_history #(.CHAR_W(CHAR_W)) u_hist (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .window_nxt (window_nxt),
    .lagged_nxt (lagged_nxt)
  );

  comma_detect #(.CHAR_W(CHAR_W)) u_det (
    .window (window_nxt),
    .sel    (sel),
    .hit    (hit)
  );

  assign det = bit_vld && frm_en && hit;

  boundary_ctrl #(.CHAR_W(CHAR_W)) u_bnd (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .bit_vld  (bit_vld),
    .det      (det),
    .boundary (boundary),
    .frm_pend (frm_pend)
  );

  // Output stage: next state, then registers.
  logic [CHAR_W-1:0] char_d;
  logic              stb_d, frm_d;

  always_comb begin
    char_d = char_out;
    stb_d  = boundary;
    frm_d  = boundary && frm_pend;
    if (boundary) begin
      char_d = lagged_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      char_out <= '0;
      char_stb <= 1'b0;
      char_frm <= 1'b0;
    end else begin
      char_stb <= stb_d;
      char_frm <= frm_d;
      if (boundary) begin
        char_out <= char_d;
      end
    end
  end

  // Observation counters for the properties below.
  logic [GW-1:0] since_stb, since_anchor;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      since_stb    <= '0;
      since_anchor <= '0;
    end else if (bit_vld) begin
      since_stb    <= boundary ? '0 : ((since_stb == GMAX) ? GMAX : since_stb + GW'(1));
      since_anchor <= (boundary || det) ? '0
                    : ((since_anchor == GMAX) ? GMAX : since_anchor + GW'(1));
    end
  end

  AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_ni)
    char_stb |-> $past(bit_vld)); // R2
  AST_FLAG_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_ni)
    char_frm |-> char_stb); // R8
  AST_PERIOD_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary |-> (since_stb >= GW'(CHAR_W - 1))); // R7
  AST_BOUNDARY_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (bit_vld && !frm_en && !boundary) |=> (since_anchor == $past(since_anchor) + GW'(1))); // R6
endmodule

// File: tb/tb_comma_framer.sv
`timescale 1ns/1ps
module tb_comma_framer;
  localparam int W       = 10;
  localparam int STRM    = 60;
  localparam int WDOG    = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bit_vld, bit_in, frm_en, char_sel;
  logic [W-1:0] char_out;
  logic         char_stb, char_frm;

  int vectors = 0;
  int fails   = 0;
  logic done  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic strm [1:STRM];

  always #4 clk = ~clk;

  comma_framer dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .frm_en(frm_en), .char_sel(char_sel),
    .char_out(char_out), .char_stb(char_stb), .char_frm(char_frm)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one cycle; returns at the following negedge with outputs settled.
  task automatic step(input logic v, input logic b);
    bit_vld = v;
    bit_in  = b;
    @(negedge clk);
  endtask

  task automatic run_case(input logic sel, input logic [W-1:0] pat,
                          input logic en, input int p);
    logic hit;
    int   e, n;
    string tag;
    logic [W-1:0] cexp;
    logic sexp, fexp;
    for (int i = 1; i <= STRM; i++) strm[i] = 1'b0;
    for (int k = 0; k < W; k++) strm[p + 1 + k] = pat[W-1-k];
    if (sel)
      hit = en && (pat == 10'b0011111010 || pat == 10'b1100000101);
    else
      hit = en && (pat[9:2] == 8'b00111110 || pat[9:2] == 8'b11000001);
    e = p + W;
    if (!en)             tag = "R6";
    else if (!hit)       tag = "R5";
    else if (e % W == 0) tag = "R9";
    else if (sel)        tag = "R7";
    else                 tag = "R4";

    bit_vld = 1'b0; bit_in = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frm_en = en; char_sel = sel;
    chk("R1 reset", {char_stb, char_frm, 8'h00}, '0);
    chk("R1 reset", char_out, '0);

    n = 0;
    while (n < STRM) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && lfsr[3]) begin
        step(1'b0, lfsr[5]);
        chk("R2 idle", {8'h00, char_stb, char_frm}, '0);
      end
      n++;
      step(1'b1, strm[n]);
      if (hit)
        sexp = (n < e + W) ? ((n % W == 0) && (n <= e)) : ((n - e) % W == 0);
      else
        sexp = (n % W == 0);
      fexp = hit && (n == e + W);
      chk(sexp ? {tag, " strobe"} : {tag, " R2 no strobe"}, {9'h0, char_stb}, {9'h0, sexp});
      chk("R8 flag", {9'h0, char_frm}, {9'h0, fexp});
      if (sexp) begin
        for (int k = 0; k < W; k++) begin
          int idx;
          idx = n - 2*W + 1 + k;
          cexp[W-1-k] = (idx >= 1) ? strm[idx] : 1'b0;
        end
        chk("R3 char", char_out, cexp);
      end
    end
  endtask

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 10'b0011111010;
    pats[1] = 10'b1100000101;
    pats[2] = 10'b0011111001;
    pats[3] = 10'b1100000110;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; frm_en = 1'b0; char_sel = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int q = 0; q < 4; q++)
        for (int en = 0; en < 2; en++)
          for (int p = 0; p < 2*W; p++)
            run_case(s[0], pats[q], en[0], p);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule